// File: doc/BRIEF.md
# ECC Error Flag and Event Controller

This block sits after the error-correction decoder of a memory array. The decoder reports two kinds of trouble on each read, each as a one-cycle pulse. A correctable pulse means a single bit was found and fixed. An uncorrectable pulse means the stored word is beyond repair. For each kind the controller keeps a sticky status flag. It turns those flags into system events according to a fixed escalation policy.

Each error class has its own interrupt enable. A flag whose enable is set raises a non-maskable interrupt request. A pending-interrupt vector names the most urgent qualified source, and the uncorrectable source outranks the correctable one. An uncorrectable error always raises a power-up-clear request. When the reset-enable input is set, the same error also raises a system reset request. A reset-vector value records which reset class was taken last.

Software clears the flags through write-one-to-clear strobes. All event requests are single-cycle pulses taken from rising edges. A flag that is already set therefore raises no second event until it has been cleared.

Top module: `ecc_evt_ctrl`

## Requirements
- R1: A pulse on `cor_err_i` makes `cor_flag_o` read 1 from the next cycle on.
- R2: `nmi_req_o` pulses for exactly one cycle when the term (`cor_flag_o` AND `cor_ie_i`) goes from 0 to 1. This includes the case where the enable is set while the flag is already standing.
- R3: A pulse on `unc_err_i` makes `unc_flag_o` read 1 from the next cycle on.
- R4: `nmi_req_o` pulses for exactly one cycle when the term (`unc_flag_o` AND `unc_ie_i`) goes from 0 to 1.
- R5: `sys_rst_req_o` pulses in the same cycle as a `puc_req_o` pulse when `rst_en_i` is 1 in that cycle. Otherwise it stays 0.
- R6: `nmi_vec_o` reads 4 while the uncorrectable flag and its enable are both set. Otherwise it reads 2 while the correctable flag and its enable are both set, and 0 in all other cases.
- R7: `puc_req_o` pulses for one cycle in the first cycle `unc_flag_o` reads 1 after reading 0, whatever the enables are.
- R8: One cycle after a `puc_req_o` pulse, `rst_vec_o` reads 2 if `rst_en_i` was 1 during the pulse, else 1. It holds that value until the next such pulse or a reset.
- R9: Each flag holds until its clear strobe (`cor_clr_i` or `unc_clr_i`) is seen, and is 0 in the cycle after the strobe. When the error pulse and the clear strobe of one flag arrive in the same cycle, the flag stays set.
- R10: While `rst` is high at a clock edge, both flags, both vectors and all request outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cor_err_i | input | 1 | Decoder pulse: corrected single-bit error |
| unc_err_i | input | 1 | Decoder pulse: uncorrectable error |
| cor_ie_i | input | 1 | Interrupt enable for the correctable flag |
| unc_ie_i | input | 1 | Interrupt enable for the uncorrectable flag |
| rst_en_i | input | 1 | Escalate uncorrectable errors to a system reset |
| cor_clr_i | input | 1 | Write-one-to-clear strobe, correctable flag |
| unc_clr_i | input | 1 | Write-one-to-clear strobe, uncorrectable flag |
| cor_flag_o | output | 1 | Sticky correctable-error flag |
| unc_flag_o | output | 1 | Sticky uncorrectable-error flag |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |
| sys_rst_req_o | output | 1 | System reset request pulse |
| puc_req_o | output | 1 | Power-up-clear request pulse |
| nmi_vec_o | output | 3 | Pending interrupt source code (0, 2, 4) |
| rst_vec_o | output | 3 | Last reset class logged (0, 1, 2) |

## Verification
The bench builds the block with the package defaults: two error sources and 3-bit vector codes. With those values every code of both vectors can be reached and compared against a behavioural model. Directed phases place error pulses and clear strobes in the same cycle. They raise an enable while a flag is already standing, repeat an uncorrectable error onto a set flag, and toggle the reset enable between events. A randomised phase then mixes all inputs, so that enable changes fall on every alignment relative to the edges of the flags.

// File: rtl/ecc_evt_pkg.sv
package ecc_evt_pkg;

    localparam int NSRC    = 2;
    localparam int SRC_COR = 0;
    localparam int SRC_UNC = 1;
    localparam int VEC_W   = 3;

    typedef enum logic [VEC_W-1:0] {
        IV_NONE = 3'd0,
        IV_COR  = 3'd2,
        IV_UNC  = 3'd4
    } ivec_e;

    typedef enum logic [VEC_W-1:0] {
        RV_NONE   = 3'd0,
        RV_PUC    = 3'd1,
        RV_SYSRST = 3'd2
    } rvec_e;

    typedef struct packed {
        logic nmi;
        logic sysrst;
        logic puc;
    } evt_t;

    function automatic ivec_e pick_ivec(input logic [NSRC-1:0] pend);
        if (pend[SRC_UNC])      return IV_UNC;
        else if (pend[SRC_COR]) return IV_COR;
        else                    return IV_NONE;
    endfunction

endpackage

// File: rtl/ecc_flag_cell.sv
module ecc_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic pend_o,
    output logic qual_rise_o,
    output logic flag_rise_o
);
    logic flag_q;
    logic qual_q;
    logic flag_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q      <= 1'b0;
            qual_q      <= 1'b0;
            flag_prev_q <= 1'b0;
        end else begin
            flag_q      <= set_i | (flag_q & ~clr_i);
            qual_q      <= flag_q & en_i;
            flag_prev_q <= flag_q;
        end
    end

    assign flag_o      = flag_q;
    assign pend_o      = flag_q & en_i;
    assign qual_rise_o = pend_o & ~qual_q;
    assign flag_rise_o = flag_q & ~flag_prev_q;

    // Set beats a clear in the same cycle
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    // A flag only drops on a clear strobe
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        flag_o && !clr_i |=> flag_o);
    // Qualified edge is a single-cycle pulse
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        qual_rise_o |=> !qual_rise_o);

endmodule

// File: rtl/ecc_evt_route.sv
module ecc_evt_route
    import ecc_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] qual_rise_i,
    input  logic            unc_flag_rise_i,
    input  logic            rst_en_i,
    output evt_t            evt_o,
    output ivec_e           ivec_o,
    output rvec_e           rvec_o
);
    rvec_e rvec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvec_q <= RV_NONE;
        end else if (unc_flag_rise_i) begin
            rvec_q <= rst_en_i ? RV_SYSRST : RV_PUC;
        end
    end

    always_comb begin
        evt_o.nmi    = |qual_rise_i;
        evt_o.puc    = unc_flag_rise_i;
        evt_o.sysrst = unc_flag_rise_i & rst_en_i;
    end

    assign ivec_o = pick_ivec(pend_i);
    assign rvec_o = rvec_q;

    // Escalated reset never occurs without the clear-reset request
    assert_rst_with_puc_R5: assert property (@(posedge clk) disable iff (rst)
        evt_o.sysrst |-> evt_o.puc);
    // Reset class is logged one cycle after the request
    assert_rvec_logged_R8: assert property (@(posedge clk) disable iff (rst)
        evt_o.puc |=> rvec_o != RV_NONE);

endmodule

// File: rtl/ecc_evt_ctrl.sv
module ecc_evt_ctrl
    import ecc_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cor_err_i,
    input  logic             unc_err_i,
    input  logic             cor_ie_i,
    input  logic             unc_ie_i,
    input  logic             rst_en_i,
    input  logic             cor_clr_i,
    input  logic             unc_clr_i,
    output logic             cor_flag_o,
    output logic             unc_flag_o,
    output logic             nmi_req_o,
    output logic             sys_rst_req_o,
    output logic             puc_req_o,
    output logic [VEC_W-1:0] nmi_vec_o,
    output logic [VEC_W-1:0] rst_vec_o
);
    logic [NSRC-1:0] set_v, clr_v, en_v, flag_v, pend_v, qrise_v, frise_v;
    evt_t  evt;
    ivec_e ivec;
    rvec_e rvec;

    always_comb begin
        set_v[SRC_COR] = cor_err_i;
        set_v[SRC_UNC] = unc_err_i;
        clr_v[SRC_COR] = cor_clr_i;
        clr_v[SRC_UNC] = unc_clr_i;
        en_v[SRC_COR]  = cor_ie_i;
        en_v[SRC_UNC]  = unc_ie_i;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        ecc_flag_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .set_i       (set_v[s]),
            .clr_i       (clr_v[s]),
            .en_i        (en_v[s]),
            .flag_o      (flag_v[s]),
            .pend_o      (pend_v[s]),
            .qual_rise_o (qrise_v[s]),
            .flag_rise_o (frise_v[s])
        );
    end

    ecc_evt_route u_route (
        .clk             (clk),
        .rst             (rst),
        .pend_i          (pend_v),
        .qual_rise_i     (qrise_v),
        .unc_flag_rise_i (frise_v[SRC_UNC]),
        .rst_en_i        (rst_en_i),
        .evt_o           (evt),
        .ivec_o          (ivec),
        .rvec_o          (rvec)
    );

    assign cor_flag_o    = flag_v[SRC_COR];
    assign unc_flag_o    = flag_v[SRC_UNC];
    assign nmi_req_o     = evt.nmi;
    assign sys_rst_req_o = evt.sysrst;
    assign puc_req_o     = evt.puc;
    assign nmi_vec_o     = ivec;
    assign rst_vec_o     = rvec;

    assert_cor_flag_R1: assert property (@(posedge clk) disable iff (rst)
        cor_err_i |=> cor_flag_o);
    assert_unc_flag_R3: assert property (@(posedge clk) disable iff (rst)
        unc_err_i |=> unc_flag_o);
    assert_unc_nmi_R4: assert property (@(posedge clk) disable iff (rst)
        unc_err_i && !unc_flag_o && unc_ie_i ##1 unc_ie_i |-> nmi_req_o);
    assert_unc_prio_R6: assert property (@(posedge clk) disable iff (rst)
        unc_flag_o && unc_ie_i |-> nmi_vec_o == 3'd4);
    assert_new_unc_puc_R7: assert property (@(posedge clk) disable iff (rst)
        unc_err_i && !unc_flag_o |=> puc_req_o);

endmodule

// File: tb/ecc_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module ecc_evt_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cor_err_i = 0, unc_err_i = 0, cor_ie_i = 0, unc_ie_i = 0;
    logic rst_en_i = 0, cor_clr_i = 0, unc_clr_i = 0;
    logic cor_flag_o, unc_flag_o, nmi_req_o, sys_rst_req_o, puc_req_o;
    logic [2:0] nmi_vec_o, rst_vec_o;

    always #2.5 clk = ~clk;

    ecc_evt_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cor_err_i(cor_err_i), .unc_err_i(unc_err_i),
        .cor_ie_i(cor_ie_i), .unc_ie_i(unc_ie_i), .rst_en_i(rst_en_i),
        .cor_clr_i(cor_clr_i), .unc_clr_i(unc_clr_i),
        .cor_flag_o(cor_flag_o), .unc_flag_o(unc_flag_o),
        .nmi_req_o(nmi_req_o), .sys_rst_req_o(sys_rst_req_o),
        .puc_req_o(puc_req_o), .nmi_vec_o(nmi_vec_o), .rst_vec_o(rst_vec_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit started  = 0;
    bit done     = 0;

    // Behavioural reference state
    int m_cf, m_uf;           // flags
    int m_cq_prev, m_uq_prev; // qualified terms seen at last edge
    int m_uf_prev;            // uncorrectable flag at last edge
    int m_rvec;

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            m_cf = 0; m_uf = 0; m_cq_prev = 0; m_uq_prev = 0;
            m_uf_prev = 0; m_rvec = 0;
        end else begin
            int ncf, nuf;
            if (m_uf && !m_uf_prev) m_rvec = rst_en_i ? 2 : 1;
            m_cq_prev = m_cf & cor_ie_i;
            m_uq_prev = m_uf & unc_ie_i;
            m_uf_prev = m_uf;
            ncf = cor_err_i ? 1 : (cor_clr_i ? 0 : m_cf);
            nuf = unc_err_i ? 1 : (unc_clr_i ? 0 : m_uf);
            m_cf = ncf;
            m_uf = nuf;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            int e_nmi, e_puc, e_srst, e_vec;
            e_nmi  = ((m_cf & cor_ie_i) & ~m_cq_prev) | ((m_uf & unc_ie_i) & ~m_uq_prev);
            e_puc  = m_uf & ~m_uf_prev;
            e_srst = e_puc & rst_en_i;
            e_vec  = (m_uf && unc_ie_i) ? 4 : ((m_cf && cor_ie_i) ? 2 : 0);
            check("R1 cor_flag", cor_flag_o, m_cf);
            check("R3 unc_flag", unc_flag_o, m_uf);
            check("R2/R4 nmi_req", nmi_req_o, e_nmi);
            check("R7 puc_req", puc_req_o, e_puc);
            check("R5 sys_rst_req", sys_rst_req_o, e_srst);
            check("R6 nmi_vec", nmi_vec_o, e_vec);
            check("R8 rst_vec", rst_vec_o, m_rvec);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        while (cycles < 20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
            cor_err_i = 0; unc_err_i = 0; cor_clr_i = 0; unc_clr_i = 0;
        end
    endtask

    initial begin
        tick(3);
        rst = 0;
        // R10: reset state
        @(negedge clk);
        check("R10 reset flags", {cor_flag_o, unc_flag_o}, 0);
        check("R10 reset vecs", {nmi_vec_o, rst_vec_o}, 0);
        tick(1);

        // R1/R2: correctable error, enable raised later
        cor_err_i = 1; tick(3);
        cor_ie_i = 1; tick(3);
        // R9: clear
        cor_clr_i = 1; tick(2);
        // R9: set and clear together
        cor_err_i = 1; tick(1);
        cor_err_i = 1; cor_clr_i = 1; tick(3);
        cor_clr_i = 1; tick(2);

        // R3/R4/R7/R8: uncorrectable without escalation
        unc_ie_i = 1; unc_err_i = 1; tick(3);
        // repeat onto a standing flag: no new PUC
        unc_err_i = 1; tick(3);
        unc_clr_i = 1; tick(2);

        // R5/R8: with escalation
        rst_en_i = 1; unc_err_i = 1; tick(3);
        unc_clr_i = 1; rst_en_i = 0; tick(2);

        // R6: both sources in the same cycle
        cor_err_i = 1; unc_err_i = 1; tick(3);
        unc_clr_i = 1; tick(3);
        unc_ie_i = 0; unc_err_i = 1; tick(3);
        cor_clr_i = 1; unc_clr_i = 1; tick(2);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            cor_err_i = ($urandom_range(0, 7) == 0);
            unc_err_i = ($urandom_range(0, 11) == 0);
            cor_clr_i = ($urandom_range(0, 5) == 0);
            unc_clr_i = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 7) == 0) cor_ie_i = ~cor_ie_i;
            if ($urandom_range(0, 7) == 0) unc_ie_i = ~unc_ie_i;
            if ($urandom_range(0, 9) == 0) rst_en_i = ~rst_en_i;
            @(posedge clk); #1;
        end
        cor_err_i = 0; unc_err_i = 0; cor_clr_i = 0; unc_clr_i = 0;

        // R10: reset mid-run clears everything
        unc_err_i = 1; cor_err_i = 1; tick(2);
        rst = 1; tick(2);
        rst = 0;
        @(negedge clk);
        check("R10 post-reset flags", {cor_flag_o, unc_flag_o}, 0);
        check("R10 post-reset vecs", {nmi_vec_o, rst_vec_o}, 0);
        tick(2);
        finish_run();
    end

endmodule